// File: doc/BRIEF.md
# Phase Accumulator Waveform Oscillator

This block is one voice oscillator for a sound synthesizer. A 24-bit phase accumulator adds a 16-bit frequency word on every clock, so the output pitch is the frequency word times the clock rate divided by 2^24. The top twelve accumulator bits feed three shapers: a sawtooth, a triangle and a pulse. Any combination of them, plus an externally supplied 12-bit noise word, can be selected at once. The selected values are merged into one 12-bit sample.

Software programs the voice through byte-wide writes. There is a two-byte frequency word, a 12-bit pulse threshold and one control byte. The control byte selects the shapers and sets the test, ring-modulation and hard-sync options. Ring modulation folds the triangle on the exclusive-OR of this voice's MSB and a neighbour's MSB. Hard sync clears this voice's accumulator when a neighbour reports that its MSB has just risen. Both neighbour signals come from other instances of this block.

If every shaper is deselected, the last sample is held for a parameterised number of clocks before it falls to zero.

Top module: `wave_osc`

## Requirements
- R1: On each clock where test is clear and no sync clear occurs, the accumulator increases by the frequency word modulo 2^24, so 4096 steps of 0x1000 return it to zero.
- R2: While the test bit is set, the accumulator is cleared at every clock; counting restarts from zero once test is cleared.
- R3: Writes use wr_addr 0 for the frequency low byte, 1 for the frequency high byte, 2 for the pulse-threshold low byte, 3 for the threshold upper nibble (wr_data bits 3:0 only) and 4 for the control byte; each write takes effect at the clock edge that samples it.
- R4: With only the sawtooth selected, the output equals accumulator bits 23:12.
- R5: With only the triangle selected, the output is accumulator bits 22:12, inverted when the fold bit is 1, then shifted left by one. The fold bit is accumulator bit 23, exclusive-ORed with ring_msb_in when ring modulation is enabled.
- R6: The pulse shaper yields 0xFFF when accumulator bits 23:12 were greater than or equal to the threshold on the previous clock, and 0x000 otherwise.
- R7: While test is set, the pulse shaper yields 0xFFF whatever the threshold.
- R8: msb_rise_out is high for exactly one cycle after the clock edge at which accumulator bit 23 changes from 0 to 1, and acc_msb_out shows bit 23.
- R9: When the sync-enable control bit is set, a high sync_in clears the accumulator at that clock edge; when sync-enable is clear, sync_in has no effect.
- R10: When no shaper is selected, the output keeps the last selected value for HOLD_CYCLES-1 clocks after the deselecting edge and reads zero from the HOLD_CYCLES-th clock onward.
- R11: Control byte bits are 7 noise, 6 pulse, 5 sawtooth, 4 triangle, 3 test, 2 ring, 1 sync-enable. With several selected, the output is the bitwise AND of the selected shaper values, and noise_in is used as-is.
- R12: A synchronous active-high reset clears the accumulator, frequency word, threshold, control byte, held sample and strobe, so the output reads zero.
- R13: wave_rd always equals bits 11:4 of wave_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write byte |
| noise_in | input | 12 | External noise word |
| ring_msb_in | input | 1 | Neighbour accumulator MSB for ring modulation |
| sync_in | input | 1 | Neighbour MSB-rise strobe for hard sync |
| wave_out | output | 12 | Combined waveform sample |
| wave_rd | output | 8 | Upper 8 bits of the sample |
| acc_msb_out | output | 1 | Accumulator MSB, for a neighbour's ring modulation |
| msb_rise_out | output | 1 | One-cycle strobe on an accumulator MSB rise |

## Verification
A corrupted accumulator is visible on the very next sample with the sawtooth selected, since the output mirrors its top bits one-to-one. The MSB strobe also shifts by whole periods. A wrong pulse pipeline shows up as a transition one clock early or late at the threshold crossing. The stimulus places the crossing exactly on the sampled cycle. A faulty hold counter is caught by sampling on the last holding cycle and on the first zero cycle. Fold, ring and AND-merge errors produce distinct 12-bit values that are computed by hand from the accumulator count.

// File: rtl/wosc_pkg.sv
package wosc_pkg;

   // register select codes, decoded by the write port
   typedef enum logic [2:0] {
      SEL_FREQ_LO = 3'd0,
      SEL_FREQ_HI = 3'd1,
      SEL_THR_LO  = 3'd2,
      SEL_THR_HI  = 3'd3,
      SEL_CTRL    = 3'd4
   } reg_sel_e;

   // control byte, bits 7 down to 1 (bit 0 is not stored)
   typedef struct packed {
      logic use_noise;
      logic use_pulse;
      logic use_saw;
      logic use_tri;
      logic test;
      logic ring;
      logic sync_en;
   } ctrl_t;

endpackage

// File: rtl/wosc_regs.sv
module wosc_regs
   import wosc_pkg::*;
#(
   parameter int FREQ_W = 16,
   parameter int THR_W  = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [7:0]        wr_data,
   output logic [FREQ_W-1:0] freq,
   output logic [THR_W-1:0]  thr,
   output ctrl_t             ctrl
);
   localparam int FREQ_HI_W = FREQ_W - 8;
   localparam int THR_HI_W  = THR_W - 8;

   initial begin : p_param_chk
      assert (FREQ_W > 8 && FREQ_W <= 16)
         else $fatal(1, "wosc_regs: FREQ_W must be 9..16");
      assert (THR_W > 8 && THR_W <= 16)
         else $fatal(1, "wosc_regs: THR_W must be 9..16");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         freq <= '0;
         thr  <= '0;
         ctrl <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            SEL_FREQ_LO: freq[7:0]        <= wr_data;
            SEL_FREQ_HI: freq[FREQ_W-1:8] <= wr_data[FREQ_HI_W-1:0];
            SEL_THR_LO:  thr[7:0]         <= wr_data;
            SEL_THR_HI:  thr[THR_W-1:8]   <= wr_data[THR_HI_W-1:0];
            SEL_CTRL:    ctrl             <= ctrl_t'(wr_data[7:1]);
            default: ;
         endcase
      end
   end

   // R3: a control write lands at the sampling edge
   a_r3_ctrl_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == SEL_CTRL) |=> (ctrl == ctrl_t'($past(wr_data[7:1]))));

endmodule

// File: rtl/wosc_phase.sv
module wosc_phase #(
   parameter int ACC_W  = 24,
   parameter int FREQ_W = 16,
   parameter int TOP_W  = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FREQ_W-1:0] freq,
   input  logic              test,
   input  logic              sync_en,
   input  logic              sync_in,
   output logic [TOP_W-1:0]  acc_top,
   output logic              msb_rise
);
   localparam int PAD_W = ACC_W - FREQ_W;

   initial begin : p_param_chk
      assert (FREQ_W < ACC_W && TOP_W <= ACC_W)
         else $fatal(1, "wosc_phase: widths inconsistent");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic             hard_clear;

   assign acc_sum    = acc_q + {{PAD_W{1'b0}}, freq};
   assign hard_clear = sync_en & sync_in;
   assign acc_top    = acc_q[ACC_W-1 -: TOP_W];

   always_ff @(posedge clk) begin
      if (rst || test) begin
         acc_q    <= '0;
         msb_rise <= 1'b0;
      end else if (hard_clear) begin
         acc_q    <= '0;
         msb_rise <= 1'b0;
      end else begin
         acc_q    <= acc_sum;
         msb_rise <= acc_sum[ACC_W-1] & ~acc_q[ACC_W-1];
      end
   end

   // R1: free-running step
   a_r1_step: assert property (@(posedge clk) disable iff (rst)
      (!test && !(sync_en && sync_in)) |=>
      (acc_q == $past(acc_q) + {{PAD_W{1'b0}}, $past(freq)}));

   // R2: test bit pins the phase at zero
   a_r2_test_zero: assert property (@(posedge clk) disable iff (rst)
      test |=> (acc_q == '0));

   // R8: the strobe lasts one cycle and coincides with a set MSB
   a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
      msb_rise |=> !msb_rise);
   a_r8_msb_high: assert property (@(posedge clk) disable iff (rst)
      msb_rise |-> acc_q[ACC_W-1]);

   // R9: enabled sync clears the phase
   a_r9_sync_clear: assert property (@(posedge clk) disable iff (rst)
      (sync_en && sync_in) |=> (acc_q == '0));

endmodule

// File: rtl/wosc_shaper.sv
module wosc_shaper #(
   parameter int OUT_W       = 12,
   parameter int HOLD_CYCLES = 64,
   parameter bit PULSE_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OUT_W-1:0] acc_top,
   input  logic             fold_flip,
   input  logic [OUT_W-1:0] thr,
   input  logic             test,
   input  logic             use_tri,
   input  logic             use_saw,
   input  logic             use_pulse,
   input  logic             use_noise,
   input  logic [OUT_W-1:0] noise,
   output logic [OUT_W-1:0] wave
);
   localparam int LOW_W = OUT_W - 1;
   localparam int TTL_W = $clog2(HOLD_CYCLES + 1);

   initial begin : p_param_chk
      assert (OUT_W >= 8) else $fatal(1, "wosc_shaper: OUT_W too small");
      assert (HOLD_CYCLES >= 1) else $fatal(1, "wosc_shaper: HOLD_CYCLES must be >= 1");
   end

   // triangle: fold the lower bits on the (possibly ring-flipped) MSB
   logic             fold;
   logic [OUT_W-1:0] tri_w;
   assign fold  = acc_top[OUT_W-1] ^ fold_flip;
   assign tri_w = {acc_top[LOW_W-1:0] ^ {LOW_W{fold}}, 1'b0};

   // pulse: compare, optionally one stage late
   logic pulse_hi;
   logic cmp_now;
   assign cmp_now = test | (acc_top >= thr);

   generate
      if (PULSE_DELAY) begin : g_pulse_reg
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (rst) pulse_q <= 1'b0;
            else     pulse_q <= cmp_now;
         end
         assign pulse_hi = pulse_q;

         // R7: test forces the pulse level high on the following cycle
         a_r7_test_pulse: assert property (@(posedge clk) disable iff (rst)
            test |=> pulse_hi);
         // R6: the level reflects the previous cycle's compare
         a_r6_lag: assert property (@(posedge clk) disable iff (rst)
            (!test && acc_top < thr) |=> !pulse_hi);
      end else begin : g_pulse_comb
         assign pulse_hi = cmp_now;
      end
   endgenerate

   // merge of the selected shapers
   logic [OUT_W-1:0] merged;
   logic             any_sel;
   assign any_sel = use_tri | use_saw | use_pulse | use_noise;

   always_comb begin
      merged = '1;
      if (use_tri)   merged = merged & tri_w;
      if (use_saw)   merged = merged & acc_top;
      if (use_pulse) merged = merged & {OUT_W{pulse_hi}};
      if (use_noise) merged = merged & noise;
   end

   // hold of the last sample when nothing is selected
   logic [OUT_W-1:0] held_q;
   logic [TTL_W-1:0] ttl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q <= '0;
         ttl_q  <= '0;
      end else if (any_sel) begin
         held_q <= merged;
         ttl_q  <= TTL_W'(HOLD_CYCLES);
      end else if (ttl_q != '0) begin
         ttl_q <= ttl_q - 1'b1;
         if (ttl_q == TTL_W'(1)) held_q <= '0;
      end
   end

   assign wave = any_sel ? merged : held_q;

   // R10: held value stays while time remains, clears when it expires
   a_r10_keep: assert property (@(posedge clk) disable iff (rst)
      (!any_sel && ttl_q > TTL_W'(1)) |=> (held_q == $past(held_q)));
   a_r10_expire: assert property (@(posedge clk) disable iff (rst)
      (!any_sel && ttl_q == TTL_W'(1)) |=> (held_q == '0));

endmodule

// File: rtl/wave_osc.sv
module wave_osc
   import wosc_pkg::*;
#(
   parameter int ACC_W       = 24,
   parameter int FREQ_W      = 16,
   parameter int OUT_W       = 12,
   parameter int HOLD_CYCLES = 64,
   parameter bit PULSE_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [11:0]      noise_in,
   input  logic             ring_msb_in,
   input  logic             sync_in,
   output logic [11:0]      wave_out,
   output logic [7:0]       wave_rd,
   output logic             acc_msb_out,
   output logic             msb_rise_out
);
   localparam int RD_W = 8;

   initial begin : p_param_chk
      assert (OUT_W == 12) else $fatal(1, "wave_osc: port width assumes OUT_W == 12");
   end

   logic [FREQ_W-1:0] freq;
   logic [OUT_W-1:0]  thr;
   ctrl_t             ctrl;
   logic [OUT_W-1:0]  acc_top;
   logic [OUT_W-1:0]  sample;

   wosc_regs #(.FREQ_W(FREQ_W), .THR_W(OUT_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .freq    (freq),
      .thr     (thr),
      .ctrl    (ctrl)
   );

   wosc_phase #(.ACC_W(ACC_W), .FREQ_W(FREQ_W), .TOP_W(OUT_W)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .freq     (freq),
      .test     (ctrl.test),
      .sync_en  (ctrl.sync_en),
      .sync_in  (sync_in),
      .acc_top  (acc_top),
      .msb_rise (msb_rise_out)
   );

   wosc_shaper #(
      .OUT_W       (OUT_W),
      .HOLD_CYCLES (HOLD_CYCLES),
      .PULSE_DELAY (PULSE_DELAY)
   ) u_shaper (
      .clk       (clk),
      .rst       (rst),
      .acc_top   (acc_top),
      .fold_flip (ctrl.ring & ring_msb_in),
      .thr       (thr),
      .test      (ctrl.test),
      .use_tri   (ctrl.use_tri),
      .use_saw   (ctrl.use_saw),
      .use_pulse (ctrl.use_pulse),
      .use_noise (ctrl.use_noise),
      .noise     (noise_in),
      .wave      (sample)
   );

   assign wave_out    = sample;
   assign wave_rd     = sample[OUT_W-1 -: RD_W];
   assign acc_msb_out = acc_top[OUT_W-1];

   // R12: the cycle after reset shows a quiet output
   a_r12_reset_quiet: assert property (@(posedge clk)
      rst |=> (wave_out == '0 && !msb_rise_out));

endmodule

// File: tb/wave_osc_tb_top.sv
module wave_osc_tb_top;
   localparam int HOLD = 64;
   localparam int NV   = 20;

   typedef struct packed {
      logic [15:0] freq;
      logic [7:0]  thr_lo;
      logic [7:0]  thr_hi;
      logic [3:0]  sel;    // {noise, pulse, saw, tri}
      logic        ring;
      logic        rmsb;
      logic [11:0] noise;
      logic [15:0] k;
      logic [11:0] expv;
      logic [7:0]  req;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{16'h1000, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b0, 12'h000, 16'd5,     12'h005, 8'd4},  // R4
      '{16'h1000, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b0, 12'h000, 16'd100,   12'h064, 8'd4},  // R4
      '{16'h1000, 8'h00, 8'h00, 4'b0001, 1'b0, 1'b0, 12'h000, 16'd5,     12'h00A, 8'd5},  // R5
      '{16'h8000, 8'h00, 8'h00, 4'b0001, 1'b0, 1'b0, 12'h000, 16'd300,   12'hD3E, 8'd5},  // R5 fold
      '{16'h1000, 8'h00, 8'h00, 4'b0001, 1'b1, 1'b1, 12'h000, 16'd5,     12'hFF4, 8'd5},  // R5 ring
      '{16'h8000, 8'h00, 8'h00, 4'b0001, 1'b1, 1'b1, 12'h000, 16'd300,   12'h2C0, 8'd5},  // R5 ring
      '{16'h1000, 8'h00, 8'h00, 4'b0001, 1'b1, 1'b0, 12'h000, 16'd5,     12'h00A, 8'd5},  // R5 ring idle
      '{16'h1000, 8'h03, 8'h00, 4'b0100, 1'b0, 1'b0, 12'h000, 16'd4,     12'hFFF, 8'd6},  // R6
      '{16'h1000, 8'h04, 8'h00, 4'b0100, 1'b0, 1'b0, 12'h000, 16'd4,     12'h000, 8'd6},  // R6 lag
      '{16'h1000, 8'h04, 8'h00, 4'b0100, 1'b0, 1'b0, 12'h000, 16'd5,     12'hFFF, 8'd6},  // R6
      '{16'h1000, 8'h00, 8'hF1, 4'b0100, 1'b0, 1'b0, 12'h000, 16'h0101,  12'hFFF, 8'd3},  // R3
      '{16'h1000, 8'h00, 8'hF1, 4'b0100, 1'b0, 1'b0, 12'h000, 16'h0100,  12'h000, 8'd3},  // R3
      '{16'h1234, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b0, 12'h000, 16'h0100,  12'h123, 8'd3},  // R3
      '{16'h1000, 8'h00, 8'h00, 4'b0011, 1'b0, 1'b0, 12'h000, 16'd5,     12'h000, 8'd11}, // R11
      '{16'h1000, 8'h00, 8'h00, 4'b0011, 1'b0, 1'b0, 12'h000, 16'd6,     12'h004, 8'd11}, // R11
      '{16'h1000, 8'h00, 8'h00, 4'b0110, 1'b0, 1'b0, 12'h000, 16'd7,     12'h007, 8'd11}, // R11
      '{16'h1000, 8'h00, 8'h00, 4'b1000, 1'b0, 1'b0, 12'hA5C, 16'd3,     12'hA5C, 8'd11}, // R11
      '{16'h1000, 8'h00, 8'h00, 4'b1010, 1'b0, 1'b0, 12'hA5C, 16'd255,   12'h05C, 8'd11}, // R11
      '{16'h1000, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b0, 12'h000, 16'd4096,  12'h000, 8'd1},  // R1 wrap
      '{16'h1000, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b0, 12'h000, 16'd4097,  12'h001, 8'd1}   // R1
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [7:0]  wr_data;
   logic [11:0] noise_in;
   logic        ring_msb_in;
   logic        sync_in;
   logic [11:0] wave_out;
   logic [7:0]  wave_rd;
   logic        acc_msb_out;
   logic        msb_rise_out;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   wave_osc #(.HOLD_CYCLES(HOLD)) dut_i (
      .clk          (clk),
      .rst          (rst),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .noise_in     (noise_in),
      .ring_msb_in  (ring_msb_in),
      .sync_in      (sync_in),
      .wave_out     (wave_out),
      .wave_rd      (wave_rd),
      .acc_msb_out  (acc_msb_out),
      .msb_rise_out (msb_rise_out)
   );

   // called at a falling edge; returns at the falling edge after capture
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // sample plus readback (R13)
   task automatic chk_wave(input string req, input logic [11:0] expv);
      chk(req, wave_out, expv);
      chk("R13", {4'h0, wave_rd}, {4'h0, expv[11:4]});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      logic [11:0] v;
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      noise_in = '0; ring_msb_in = 1'b0; sync_in = 1'b0;
      run(3);
      rst = 1'b0;
      run(1);
      // R12: reset state
      chk_wave("R12", 12'h000);
      chk("R12", {11'h0, msb_rise_out}, 12'h000);
      chk("R12", {11'h0, acc_msb_out}, 12'h000);

      // vector table
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, VECS[i].freq[7:0]);
         wr(3'd1, VECS[i].freq[15:8]);
         wr(3'd2, VECS[i].thr_lo);
         wr(3'd3, VECS[i].thr_hi);
         noise_in    = VECS[i].noise;
         ring_msb_in = VECS[i].rmsb;
         wr(3'd4, {VECS[i].sel, 1'b1, VECS[i].ring, 2'b00});
         wr(3'd4, {VECS[i].sel, 1'b0, VECS[i].ring, 2'b00});
         run(int'(VECS[i].k));
         chk($sformatf("R%0d vec%0d", VECS[i].req, i), wave_out, VECS[i].expv);
         chk("R13", {4'h0, wave_rd}, {4'h0, VECS[i].expv[11:4]});
      end
      noise_in = '0; ring_msb_in = 1'b0;

      // R2: test clears a running sawtooth and keeps it at zero
      wr(3'd0, 8'h00); wr(3'd1, 8'h10); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd4, 8'h20);
      run(20);
      wr(3'd4, 8'h28);
      run(3);
      chk_wave("R2", 12'h000);
      run(5);
      chk_wave("R2", 12'h000);

      // R7: test forces the pulse high over a maximal threshold
      wr(3'd2, 8'hFF); wr(3'd3, 8'h0F);
      wr(3'd4, 8'h48);
      run(2);
      chk_wave("R7", 12'hFFF);
      wr(3'd4, 8'h40);
      chk_wave("R7", 12'hFFF);
      run(1);
      chk_wave("R6", 12'h000);

      // R8: strobe at the MSB rise with step 0x8000 (256 steps)
      wr(3'd0, 8'h00); wr(3'd1, 8'h80);
      wr(3'd4, 8'h28); wr(3'd4, 8'h20);
      run(255);
      chk("R8", {10'h0, acc_msb_out, msb_rise_out}, 12'h000);
      run(1);
      chk("R8", {10'h0, acc_msb_out, msb_rise_out}, 12'h003);
      run(1);
      chk("R8", {10'h0, acc_msb_out, msb_rise_out}, 12'h002);

      // R9: sync with enable clears, without enable is ignored
      wr(3'd1, 8'h10);
      wr(3'd4, 8'h2A); wr(3'd4, 8'h22);
      run(10);
      chk_wave("R9", 12'h00A);
      sync_in = 1'b1;
      run(1);
      sync_in = 1'b0;
      chk_wave("R9", 12'h000);
      run(1);
      chk_wave("R9", 12'h001);
      wr(3'd4, 8'h20);
      v = wave_out;
      sync_in = 1'b1;
      run(1);
      sync_in = 1'b0;
      chk_wave("R9", v + 12'h001);

      // R10: hold then expire
      wr(3'd4, 8'h28); wr(3'd4, 8'h20);
      run(9);
      chk_wave("R4", 12'h009);
      wr(3'd4, 8'h00);
      chk_wave("R10", 12'h009);
      run(HOLD - 1);
      chk_wave("R10", 12'h009);
      run(1);
      chk_wave("R10", 12'h000);

      // R12: reset in the middle of activity
      wr(3'd4, 8'h20);
      run(5);
      rst = 1'b1;
      run(1);
      rst = 1'b0;
      chk_wave("R12", 12'h000);
      run(4);
      chk_wave("R12", 12'h000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule